// File: doc/BRIEF.md
# Reset Cause and Break Status Registers

This block is a pair of byte-wide status registers on a simple register bus. One register holds sticky flags that record which event caused the controller's most recent reset. The other holds a single flag that says a low-power wait state ended because of a debug break. Each event reaches the block as a one-cycle pulse. Software reads the flags over the bus.

The two registers clear in different ways. Reading the reset-cause register returns its current value and empties it on the same clock edge. A power-on event replaces the whole register with its own bit. The break flag clears only when software writes a zero to its bit, or when any reset-cause event arrives.

Read data is registered and appears on the cycle after the read strobe.

Top module: `rst_cause_regs`

## Requirements
- R1: While `rstN` is low, the reset-cause register holds 0x80, the break flag is 0 and `rdData` is 0x00.
- R2: Offset 0 selects the break register and offset 1 selects the reset-cause register. A read at any other offset returns 0x00, and a write there changes no flag.
- R3: A read of the break register returns the break flag in bit 1 and 0 in every other bit, so the value is 0x02 or 0x00.
- R4: A pulse on `brkEvt` sets the break flag.
- R5: A write to offset 0 with bit 1 of `wrData` at 0 clears the break flag. A write with that bit at 1 has no effect. When a `brkEvt` pulse arrives in the same cycle as a clearing write, the flag ends up set.
- R6: Any pulse on `rstEvt` clears the break flag, even when `brkEvt` pulses in the same cycle.
- R7: Reset-cause register layout: `rstEvt[i]` maps to register bit i+1. The order from bit 7 down is power-on (`rstEvt[6]`), external pin, watchdog, illegal opcode, illegal address, monitor-mode entry, low-voltage (`rstEvt[0]`). Bit 0 always reads 0.
- R8: A power-on pulse (`rstEvt[6]`) makes the register 0x80, whatever other pulses, reads or register contents occur in the same cycle.
- R9: A pulse on any other cause sets only its own bit and keeps the bits already set. Several pulses in the same cycle set all of their bits.
- R10: A read of the reset-cause register returns its value and then clears it. A cause pulse in the same cycle as that read is set after the clear.
- R11: Writes to the reset-cause register are ignored.
- R12: `rdData` is valid in the cycle after `rdEn` and is 0x00 in any cycle after a cycle with no read. A read of the break register does not change the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register offset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| rstEvt | input | 7 | Reset-cause pulses, bit 6 power-on down to bit 0 low-voltage |
| brkEvt | input | 1 | Pulse: wait state left by a break |

## Verification
The cause register is tested with three kinds of input:
- A single pulse, which separates the bit positions from one another.
- Simultaneous and successive pulses, which show whether bits merge or overwrite.
- Pulses that coincide with a read or with a power-on, which show the precedence order.

The break flag is tested with:
- Writes of 0xFF and 0xFD, which show whether the clear depends on bit 1 alone.
- A set colliding with a write-clear, and a set colliding with a reset cause, which separate the two precedence rules.

Accesses at unused offsets and an idle cycle confirm that the address decode and the zeroing of read data do not disturb the flags.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_CAUSE = 7;
  localparam int POR_IDX   = NUM_CAUSE - 1;
  localparam int BRK_BIT   = 1;
  localparam int BRK_OFS   = 0;
  localparam int CAUSE_OFS = 1;

  typedef struct packed {
    logic rdBrk;
    logic rdCause;
    logic brkClr;
  } rcsStrobeT;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output rcsStrobeT         strb
);
  localparam logic [ADDR_W-1:0] BRK_ADDR   = ADDR_W'(BRK_OFS);
  localparam logic [ADDR_W-1:0] CAUSE_ADDR = ADDR_W'(CAUSE_OFS);

  logic hitBrk;
  logic hitCause;

  assign hitBrk   = (addr == BRK_ADDR);
  assign hitCause = (addr == CAUSE_ADDR);

  always_comb begin
    strb.rdBrk   = rdEn & hitBrk;
    strb.rdCause = rdEn & hitCause;
    strb.brkClr  = wrEn & hitBrk & ~wrData[BRK_BIT];
  end
endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  rcsStrobeT            strb,
  input  logic [NUM_CAUSE-1:0] rstEvt,
  input  logic                 brkEvt,
  output logic [DATA_W-1:0]    rdData
);
  localparam logic [DATA_W-1:0] POR_VAL = DATA_W'(1) << (POR_IDX + 1);

  logic [NUM_CAUSE-1:0] causeBits;
  logic [DATA_W-1:0]    causeVal;
  logic [DATA_W-1:0]    brkVal;
  logic                 brkFlag;
  logic                 anyCause;

  assign anyCause = |rstEvt;
  assign causeVal = {causeBits, 1'b0};

  always_comb begin
    brkVal          = '0;
    brkVal[BRK_BIT] = brkFlag;
  end

  generate
    for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_cause
      if (i == POR_IDX) begin : g_por
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)          causeBits[i] <= 1'b1;
          else if (rstEvt[i]) causeBits[i] <= 1'b1;
          else                causeBits[i] <= causeBits[i] & ~strb.rdCause;
        end
      end else begin : g_other
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                causeBits[i] <= 1'b0;
          else if (rstEvt[POR_IDX]) causeBits[i] <= 1'b0;
          else causeBits[i] <= (causeBits[i] & ~strb.rdCause) | rstEvt[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            brkFlag <= 1'b0;
    else if (anyCause)    brkFlag <= 1'b0;
    else if (brkEvt)      brkFlag <= 1'b1;
    else if (strb.brkClr) brkFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strb.rdCause) rdData <= causeVal;
    else if (strb.rdBrk)   rdData <= brkVal;
    else                   rdData <= '0;
  end

  // R8
  por_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstEvt[POR_IDX] |=> (causeVal == POR_VAL));

  // R10
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCause && !anyCause) |=> (causeVal == '0));

  // R10
  rd_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCause |=> (rdData == $past(causeVal)));

  // R4
  brk_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkEvt && !anyCause) |=> brkFlag);

  // R6
  brk_cause_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyCause |=> !brkFlag);

  // R5
  brk_wr_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.brkClr && !brkEvt && !anyCause) |=> !brkFlag);

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdCause && !strb.rdBrk) |=> (rdData == '0));

  // R7
  bit0_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCause |=> !rdData[0]);
endmodule

// File: rtl/rst_cause_regs.sv
module rst_cause_regs
  import rcs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_CAUSE-1:0] rstEvt,
  input  logic                 brkEvt
);
  rcsStrobeT strb;

  rcs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr   (addr),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .wrData (wrData),
    .strb   (strb)
  );

  rcs_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rstEvt (rstEvt),
    .brkEvt (brkEvt),
    .rdData (rdData)
  );
endmodule

// File: tb/rst_cause_regs_bench.sv
`timescale 1ns/1ps
module rst_cause_regs_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [6:0] rstEvt = '0;
  logic       brkEvt = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rst_cause_regs u_rst_cause_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .rstEvt(rstEvt), .brkEvt(brkEvt)
  );

  // vector: [43:40] req, [39:33] evt, [32] brk, [31] rd, [30] wr,
  //         [29:26] addr, [25:18] wdata, [17] chk, [7:0] expected
  function automatic logic [43:0] mk(input logic [3:0] req, input logic [6:0] evt,
      input logic brk, input logic rd, input logic wr, input logic [3:0] ad,
      input logic [7:0] wd, input logic chk, input logic [7:0] exp);
    return {req, evt, brk, rd, wr, ad, wd, chk, 9'd0, exp};
  endfunction

  localparam int N = 35;
  localparam logic [43:0] VEC [N] = '{
    mk(8,  7'h00, 0, 1, 0, 1, 8'h00, 1, 8'h80),  // R8 reset value
    mk(10, 7'h00, 0, 1, 0, 1, 8'h00, 1, 8'h00),  // R10 cleared
    mk(3,  7'h00, 0, 1, 0, 0, 8'h00, 1, 8'h00),  // R3
    mk(4,  7'h00, 1, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(4,  7'h00, 0, 1, 0, 0, 8'h00, 1, 8'h02),  // R4
    mk(5,  7'h00, 0, 0, 1, 0, 8'hFF, 0, 8'h00),
    mk(5,  7'h00, 0, 1, 0, 0, 8'h00, 1, 8'h02),  // R5 write 1 no effect
    mk(5,  7'h00, 0, 0, 1, 0, 8'hFD, 0, 8'h00),
    mk(5,  7'h00, 0, 1, 0, 0, 8'h00, 1, 8'h00),  // R5 write 0 clears
    mk(9,  7'h10, 0, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(7,  7'h00, 0, 1, 0, 1, 8'h00, 1, 8'h20),  // R7 watchdog bit
    mk(9,  7'h21, 0, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(9,  7'h08, 0, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(9,  7'h00, 0, 1, 0, 1, 8'h00, 1, 8'h52),  // R9 accumulate
    mk(11, 7'h02, 0, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(11, 7'h00, 0, 0, 1, 1, 8'hFF, 0, 8'h00),
    mk(11, 7'h00, 0, 1, 0, 1, 8'h00, 1, 8'h04),  // R11
    mk(5,  7'h00, 1, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(5,  7'h00, 1, 0, 1, 0, 8'h00, 0, 8'h00),
    mk(5,  7'h00, 0, 1, 0, 0, 8'h00, 1, 8'h02),  // R5 set wins
    mk(6,  7'h04, 1, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(6,  7'h00, 0, 1, 0, 0, 8'h00, 1, 8'h00),  // R6
    mk(7,  7'h00, 0, 1, 0, 1, 8'h00, 1, 8'h08),  // R7 illegal addr bit
    mk(10, 7'h08, 0, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(10, 7'h20, 0, 1, 0, 1, 8'h00, 1, 8'h10),  // R10 read+event
    mk(10, 7'h00, 0, 1, 0, 1, 8'h00, 1, 8'h40),  // R10 event kept
    mk(8,  7'h30, 0, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(8,  7'h48, 0, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(8,  7'h00, 0, 1, 0, 1, 8'h00, 1, 8'h80),  // R8 override
    mk(2,  7'h00, 1, 0, 0, 0, 8'h00, 0, 8'h00),
    mk(2,  7'h00, 0, 1, 0, 5, 8'h00, 1, 8'h00),  // R2 unused read
    mk(2,  7'h00, 0, 0, 1, 5, 8'h00, 0, 8'h00),
    mk(2,  7'h00, 0, 1, 0, 0, 8'h00, 1, 8'h02),  // R2 unused write
    mk(12, 7'h00, 0, 0, 0, 0, 8'h00, 1, 8'h00),  // R12 idle zero
    mk(12, 7'h00, 0, 1, 0, 0, 8'h00, 1, 8'h02)   // R12 read keeps flag
  };

  task automatic check(input int req, input logic [7:0] exp);
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL R%0d: rdData=%02h expected=%02h", req, rdData, exp);
    end
  endtask

  task automatic drive(input logic [6:0] evt, input logic brk, input logic rd,
                       input logic wr, input logic [3:0] ad, input logic [7:0] wd);
    rstEvt = evt; brkEvt = brk; rdEn = rd; wrEn = wr; addr = ad; wrData = wd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 8'h00);  // R1 rdData during reset
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      drive(VEC[i][39:33], VEC[i][32], VEC[i][31], VEC[i][30], VEC[i][29:26], VEC[i][25:18]);
      @(negedge clk);
      drive('0, 0, 0, 0, '0, '0);
      if (VEC[i][17]) check(int'(VEC[i][43:40]), VEC[i][7:0]);
    end

    // R1: reset in the middle of activity
    drive(7'h10, 0, 0, 0, 0, 8'h00); @(negedge clk);
    drive(7'h00, 1, 1, 0, 0, 8'h00); @(negedge clk);
    drive('0, 0, 0, 0, '0, '0);
    rstN = 1'b0;
    #1;
    check(1, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    drive(7'h00, 0, 1, 0, 1, 8'h00); @(negedge clk);
    drive('0, 0, 0, 0, '0, '0);
    check(1, 8'h80);  // R1 cause after reset
    drive(7'h00, 0, 1, 0, 0, 8'h00); @(negedge clk);
    drive('0, 0, 0, 0, '0, '0);
    check(1, 8'h00);  // R1 break flag after reset

    // R9: low-voltage alone lands on bit 1
    drive(7'h01, 0, 0, 0, 0, 8'h00); @(negedge clk);
    drive(7'h00, 0, 1, 0, 1, 8'h00); @(negedge clk);
    drive('0, 0, 0, 0, '0, '0);
    check(9, 8'h02);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule